// File: doc/BRIEF.md
# Receive Message Queue Status Controller

This block keeps the bookkeeping for a receive message queue in a bus controller. The receive path raises a store strobe for each incoming frame. The host raises a read-advance strobe each time it consumes the oldest frame. The block does not hold any payload. It keeps the write and read slot pointers and the count of unread messages. From these it builds a 16-bit status word that carries the empty, full, message-lost and interrupt-request flags and the unread counter.

A configuration register selects three things:
- the queue depth, 4, 8, 16 or 32 messages;
- a threshold code that raises the interrupt request when the fill level reaches a chosen eighth of the depth;
- a mode that raises the request on every accepted message instead.

The configuration register accepts writes only while the global reset mode input is high. The two sticky flags are cleared by writing 0 to their bit positions in the status word. An external payload memory writes at `wr_ptr` whenever `store_take` is high, and the host reads at `rd_ptr`.

Top module: `rxq_status_ctrl`

## Requirements
- R1: After reset, `status_word` is 0x0001 and both pointers are 0. The status word layout is as follows: bit 0 empty, bit 1 full, bit 2 message lost, bit 3 interrupt request, bits 13:8 unread count. All other bits read 0.
- R2: A configuration write (`reg_sel`=0) uses these fields: bits 2:0 depth code, bits 5:3 threshold code, bit 6 every-message mode. Depth codes 1, 2, 3 and 4 give 4, 8, 16 and 32 messages. Any other code gives no storage: stores are ignored and the queue stays empty. The unread count never exceeds 32.
- R3: An accepted store adds one to the count and advances `wr_ptr` modulo the depth. An accepted read-advance subtracts one and advances `rd_ptr` modulo the depth. A store and a read-advance in the same cycle while not full leave the count unchanged. A read-advance while empty is ignored. The status word shows each change in the cycle after the clock edge.
- R4: The full flag is 1 when the count equals the depth. A store while full is discarded, sets the message-lost flag and does not change the count. A read-advance in that same cycle is still performed.
- R5: A status write (`reg_sel`=1) clears the lost flag if bit 2 is 0 and clears the interrupt flag if bit 3 is 0. A 1 in either bit leaves that flag unchanged. A set event in the same cycle wins over the clear.
- R6: While `fifo_en` is 0, the count and both pointers go to 0, empty reads 1, full reads 0, and stores are ignored.
- R7: While `glb_rst_mode` is 1, the count, pointers, lost flag and interrupt flag are cleared. Configuration writes are accepted only in this mode and are ignored otherwise.
- R8: With every-message mode at 0 and threshold code k, the interrupt flag is set by a store (with no accepted read in the same cycle) that brings the count to depth×(k+1)/8, using integer division.
- R9: With every-message mode at 1, every accepted store sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_rst_mode | input | 1 | Global reset mode; clears state and opens the configuration register to writes |
| fifo_en | input | 1 | Queue enable |
| store_req | input | 1 | Store request from the receive path |
| read_adv | input | 1 | Read-advance strobe from the host |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the configuration register, 1 selects the status word |
| reg_wdata | input | 16 | Register write data |
| status_word | output | 16 | Status word |
| wr_ptr | output | 5 | Slot for the next accepted store |
| rd_ptr | output | 5 | Slot of the oldest unread message |
| store_take | output | 1 | The store request in this cycle is accepted |

## Verification
The properties assume that the enable and mode inputs are ordinary levels sampled at the clock edge. They also assume that a full flag seen in the status word comes from a configuration that was loaded during global reset mode. The bench keeps within these assumptions because it changes configuration only after raising the global reset mode input, and it drives every input once per cycle on the falling edge. Strobes are pulsed only through the driver task, so each one lasts exactly one cycle, and the reference model is stepped once for that cycle.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg
// Shared sizes, status bit positions, the configuration record and the
// decode helpers for the receive queue status controller.
// Assumes depths are powers of two that grow by doubling from the smallest.
package rxq_pkg;

    localparam int CODE_W        = 3;
    localparam int MIN_DEPTH_LOG = 2;
    localparam int NUM_DEPTHS    = 4;
    localparam int MAX_DEPTH     = 1 << (MIN_DEPTH_LOG + NUM_DEPTHS - 1);
    localparam int CNT_W         = $clog2(MAX_DEPTH + 1);
    localparam int PTR_W         = $clog2(MAX_DEPTH);
    localparam int WORD_W        = 16;

    localparam int BIT_EMPTY = 0;
    localparam int BIT_FULL  = 1;
    localparam int BIT_LOST  = 2;
    localparam int BIT_IRQ   = 3;
    localparam int CNT_LSB   = 8;

    localparam int NUM_STICKY = 2;
    localparam int STK_LOST   = 0;
    localparam int STK_IRQ    = 1;

    typedef struct packed {
        logic              every_msg;
        logic [CODE_W-1:0] thr_code;
        logic [CODE_W-1:0] depth_code;
    } rxq_cfg_t;

    localparam int CFG_W = $bits(rxq_cfg_t);

    // Map a depth code to a message count; unknown codes give zero.
    function automatic logic [CNT_W-1:0] depth_of(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] d;
        d = '0;
        for (int i = 1; i <= NUM_DEPTHS; i++) begin
            if (code == CODE_W'(i)) begin
                d = CNT_W'(1 << (MIN_DEPTH_LOG + i - 1));
            end
        end
        return d;
    endfunction

    // Trigger level: depth * (k + 1) / 2**CODE_W.
    function automatic logic [CNT_W-1:0] level_of(input logic [CNT_W-1:0] depth,
                                                  input logic [CODE_W-1:0] k);
        int unsigned prod;
        prod = int'(depth) * (int'(k) + 1);
        return CNT_W'(prod >> CODE_W);
    endfunction

endpackage

// File: rtl/rxq_cfg_reg.sv
// Module rxq_cfg_reg
// Holds depth code, threshold code and interrupt mode.
// Assumes the register is writable only while global reset mode is active;
// writes at any other time are dropped.
module rxq_cfg_reg
    import rxq_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output rxq_cfg_t          cfg
);

    // Load the configuration fields on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && glb_mode) begin
            cfg <= rxq_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

endmodule

// File: rtl/rxq_occupancy.sv
// Module rxq_occupancy
// Tracks unread count and the write/read slot pointers of the queue.
// Assumes depth is zero or a power of two not larger than 2**PTR_W; when
// the queue is inactive all state is held at zero.
module rxq_occupancy #(
    parameter int CNT_W = 6,
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             store_req,
    input  logic             read_adv,
    input  logic [CNT_W-1:0] depth,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full,
    output logic             store_take,
    output logic             store_drop,
    output logic             read_take
);

    logic [PTR_W-1:0] wrap_mask;
    logic [PTR_W-1:0] wr_ptr_inc;
    logic [PTR_W-1:0] rd_ptr_inc;

    // Derive the pointer wrap mask from the power-of-two depth.
    always_comb begin
        wrap_mask = PTR_W'(depth - CNT_W'(1));
    end

    // Decide which strobes take effect this cycle.
    always_comb begin
        full       = (depth != '0) && (count == depth);
        store_take = active && store_req && !full;
        store_drop = active && store_req && full;
        read_take  = active && read_adv && (count != '0);
    end

    // Next unread count from accepted store and read.
    always_comb begin
        unique case ({store_take, read_take})
            2'b10:   count_next = count + CNT_W'(1);
            2'b01:   count_next = count - CNT_W'(1);
            default: count_next = count;
        endcase
    end

    // Next pointer values, wrapped at the depth.
    always_comb begin
        wr_ptr_inc = (wr_ptr + PTR_W'(1)) & wrap_mask;
        rd_ptr_inc = (rd_ptr + PTR_W'(1)) & wrap_mask;
    end

    // Register count and pointers; clear while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            count <= count_next;
            if (store_take) begin
                wr_ptr <= wr_ptr_inc;
            end
            if (read_take) begin
                rd_ptr <= rd_ptr_inc;
            end
        end
    end

endmodule

// File: rtl/rxq_sticky_flag.sv
// Module rxq_sticky_flag
// One sticky status bit: set by an event, cleared by writing 0 to it,
// left alone by writing 1, cleared in global reset mode.
// Assumes a set event wins over a clearing write in the same cycle.
module rxq_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic glb_mode,
    input  logic set_ev,
    input  logic stat_wr,
    input  logic wr_bit,
    output logic flag
);

    // Update the flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || glb_mode) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (stat_wr && !wr_bit) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_flags.sv
// Module rxq_flags
// Builds the message-lost and interrupt-request events and keeps them in
// sticky flags.
// Assumes count_next and level are in the same units as the unread count.
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_mode,
    input  logic              store_take,
    input  logic              store_drop,
    input  logic              read_take,
    input  logic [CW-1:0]     count_next,
    input  logic [CW-1:0]     level,
    input  logic              every_msg,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              lost,
    output logic              irq
);

    logic [NUM_STICKY-1:0] set_ev;
    logic [NUM_STICKY-1:0] wr_bits;
    logic [NUM_STICKY-1:0] flags;

    // Form the set events and pick each flag's bit from the write data.
    always_comb begin
        set_ev[STK_LOST]  = store_drop;
        set_ev[STK_IRQ]   = store_take &&
                            (every_msg || (!read_take && (count_next == level)));
        wr_bits[STK_LOST] = wr_data[BIT_LOST];
        wr_bits[STK_IRQ]  = wr_data[BIT_IRQ];
    end

    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
        rxq_sticky_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .glb_mode (glb_mode),
            .set_ev   (set_ev[g]),
            .stat_wr  (stat_wr),
            .wr_bit   (wr_bits[g]),
            .flag     (flags[g])
        );
    end

    // Present the flags under their own names.
    always_comb begin
        lost = flags[STK_LOST];
        irq  = flags[STK_IRQ];
    end

endmodule

// File: rtl/rxq_status_ctrl.sv
// Module rxq_status_ctrl
// Top of the receive queue status controller: configuration, occupancy,
// sticky flags and the status word. Payload storage lives outside and
// follows wr_ptr/rd_ptr and store_take.
// Assumes all inputs are synchronous to clk.
module rxq_status_ctrl
    import rxq_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int PW     = PTR_W,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_rst_mode,
    input  logic              fifo_en,
    input  logic              store_req,
    input  logic              read_adv,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] status_word,
    output logic [PW-1:0]     wr_ptr,
    output logic [PW-1:0]     rd_ptr,
    output logic              store_take
);

    rxq_cfg_t       cfg;
    logic [CW-1:0]  depth;
    logic [CW-1:0]  level;
    logic [CW-1:0]  count;
    logic [CW-1:0]  count_next;
    logic           active;
    logic           full;
    logic           store_drop;
    logic           read_take;
    logic           lost;
    logic           irq;
    logic           cfg_wr;
    logic           stat_wr;

    // Split the register write strobe by target.
    always_comb begin
        cfg_wr  = reg_wr && !reg_sel;
        stat_wr = reg_wr && reg_sel;
    end

    // Decode depth and trigger level and decide if the queue runs.
    always_comb begin
        depth  = depth_of(cfg.depth_code);
        level  = level_of(depth, cfg.thr_code);
        active = fifo_en && !glb_rst_mode && (depth != '0);
    end

    rxq_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .glb_mode (glb_rst_mode),
        .wr_en    (cfg_wr),
        .wr_data  (reg_wdata),
        .cfg      (cfg)
    );

    rxq_occupancy #(.CNT_W(CW), .PTR_W(PW)) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .store_req  (store_req),
        .read_adv   (read_adv),
        .depth      (depth),
        .count      (count),
        .count_next (count_next),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .full       (full),
        .store_take (store_take),
        .store_drop (store_drop),
        .read_take  (read_take)
    );

    rxq_flags #(.CW(CW), .DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_mode   (glb_rst_mode),
        .store_take (store_take),
        .store_drop (store_drop),
        .read_take  (read_take),
        .count_next (count_next),
        .level      (level),
        .every_msg  (cfg.every_msg),
        .stat_wr    (stat_wr),
        .wr_data    (reg_wdata),
        .lost       (lost),
        .irq        (irq)
    );

    // Assemble the status word from registered state.
    always_comb begin
        status_word                 = '0;
        status_word[BIT_EMPTY]      = (count == '0);
        status_word[BIT_FULL]       = full;
        status_word[BIT_LOST]       = lost;
        status_word[BIT_IRQ]        = irq;
        status_word[CNT_LSB +: CW]  = count;
    end

endmodule

// File: rtl/rxq_status_ctrl_chk.sv
// Module rxq_status_ctrl_chk
// Property checker for rxq_status_ctrl, attached by bind below.
// Assumes inputs are sampled at the rising edge like the design does.
module rxq_status_ctrl_chk
    import rxq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              glb_rst_mode,
    input logic              fifo_en,
    input logic              store_req,
    input logic              read_adv,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] status_word
);

    logic [CNT_W-1:0] cnt_f;
    logic             run;
    logic             lost_clr;
    logic             irq_clr;

    // Convenience views of the observed state and clearing writes.
    always_comb begin
        cnt_f    = status_word[CNT_LSB +: CNT_W];
        run      = fifo_en && !glb_rst_mode;
        lost_clr = reg_wr && reg_sel && !reg_wdata[BIT_LOST];
        irq_clr  = reg_wr && reg_sel && !reg_wdata[BIT_IRQ];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_f <= CNT_W'(MAX_DEPTH)); // R2

    AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[BIT_EMPTY] && !store_req |=> status_word[BIT_EMPTY]); // R3

    AST_LOST_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        run && store_req && status_word[BIT_FULL] |=> status_word[BIT_LOST]); // R4

    AST_FULL_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && store_req && !read_adv && status_word[BIT_FULL] |=> $stable(cnt_f)); // R4

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_rst_mode && status_word[BIT_LOST] && !lost_clr |=> status_word[BIT_LOST]); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_rst_mode && status_word[BIT_IRQ] && !irq_clr |=> status_word[BIT_IRQ]); // R5

    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> status_word[BIT_EMPTY] && !status_word[BIT_FULL]); // R6

    AST_GLB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        glb_rst_mode |=> status_word[BIT_EMPTY] && !status_word[BIT_LOST]
                         && !status_word[BIT_IRQ]); // R7

endmodule

bind rxq_status_ctrl rxq_status_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .glb_rst_mode (glb_rst_mode),
    .fifo_en      (fifo_en),
    .store_req    (store_req),
    .read_adv     (read_adv),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .status_word  (status_word)
);

// File: tb/rxq_status_ctrl_tb.sv
module rxq_status_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        glb_rst_mode;
    logic        fifo_en;
    logic        store_req;
    logic        read_adv;
    logic        reg_wr;
    logic        reg_sel;
    logic [15:0] reg_wdata;
    logic [15:0] status_word;
    logic [4:0]  wr_ptr;
    logic [4:0]  rd_ptr;
    logic        store_take;

    always #5 clk = ~clk;

    rxq_status_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .glb_rst_mode (glb_rst_mode),
        .fifo_en      (fifo_en),
        .store_req    (store_req),
        .read_adv     (read_adv),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .status_word  (status_word),
        .wr_ptr       (wr_ptr),
        .rd_ptr       (rd_ptr),
        .store_take   (store_take)
    );

    typedef struct {
        logic [15:0] st;
        logic [4:0]  wp;
        logic [4:0]  rp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference model state
    int m_cnt = 0, m_wp = 0, m_rp = 0, m_dc = 0, m_thr = 0;
    bit m_lost = 0, m_irq = 0, m_every = 0;
    bit drv_en = 0, drv_glb = 1;

    function automatic int dep_of(int c);
        return (c >= 1 && c <= 4) ? (2 << c) : 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected result
    task automatic step(bit st, bit rd, bit we, bit sel, logic [15:0] wd, string tag);
        int d, d2, lvl, nc;
        bit act, full, acc_s, drop, acc_r, ev_irq;
        exp_t e;
        @(negedge clk);
        fifo_en      = drv_en;
        glb_rst_mode = drv_glb;
        store_req    = st;
        read_adv     = rd;
        reg_wr       = we;
        reg_sel      = sel;
        reg_wdata    = wd;
        d     = dep_of(m_dc);
        act   = drv_en && !drv_glb && d != 0;
        full  = (d != 0) && (m_cnt == d);
        acc_s = st && act && !full;
        drop  = st && act && full;
        acc_r = rd && act && m_cnt != 0;
        nc    = m_cnt + int'(acc_s) - int'(acc_r);
        lvl   = d * (m_thr + 1) / 8;
        ev_irq = acc_s && (m_every || (!acc_r && nc == lvl));
        if (!act) begin
            m_cnt = 0; m_wp = 0; m_rp = 0;
        end else begin
            m_cnt = nc;
            if (acc_s) m_wp = (m_wp + 1) % d;
            if (acc_r) m_rp = (m_rp + 1) % d;
        end
        if (drv_glb) begin
            m_lost = 0; m_irq = 0;
        end else begin
            if (we && sel && !wd[2]) m_lost = 0;
            if (drop) m_lost = 1;
            if (we && sel && !wd[3]) m_irq = 0;
            if (ev_irq) m_irq = 1;
        end
        if (we && !sel && drv_glb) begin
            m_dc = int'(wd[2:0]); m_thr = int'(wd[5:3]); m_every = wd[6];
        end
        d2 = dep_of(m_dc);
        e.st  = {2'b00, 6'(m_cnt), 4'b0000, m_irq, m_lost,
                 (d2 != 0 && m_cnt == d2), (m_cnt == 0)};
        e.wp  = 5'(m_wp);
        e.rp  = 5'(m_rp);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(string tag);  step(0, 0, 0, 0, 16'h0, tag); endtask
    task automatic store(string tag); step(1, 0, 0, 0, 16'h0, tag); endtask
    task automatic read(string tag);  step(0, 1, 0, 0, 16'h0, tag); endtask
    task automatic cfg(int dc, int thr, bit ev, string tag);
        step(0, 0, 1, 0, {9'b0, ev, 3'(thr), 3'(dc)}, tag);
    endtask
    task automatic wstat(logic [15:0] wd, string tag); step(0, 0, 1, 1, wd, tag); endtask

    // monitor: compare each expected item just after the edge it belongs to
    always @(posedge clk) begin : mon
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_cmp++;
            if (status_word !== e.st || wr_ptr !== e.wp || rd_ptr !== e.rp) begin
                n_bad++;
                $display("FAIL %s: status=%h wp=%0d rp=%0d expected status=%h wp=%0d rp=%0d",
                         e.tag, status_word, wr_ptr, rd_ptr, e.st, e.wp, e.rp);
            end
        end
    end

    initial begin : watchdog
        #500us;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin : stim
        rst_n = 0; glb_rst_mode = 1; fifo_en = 0; store_req = 0; read_adv = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        n_cmp++;
        if (status_word !== 16'h0001 || wr_ptr !== 0 || rd_ptr !== 0) begin
            n_bad++;
            $display("FAIL R1 reset: status=%h wp=%0d rp=%0d expected status=0001 wp=0 rp=0",
                     status_word, wr_ptr, rd_ptr);
        end
        // depth 4, threshold code 3 -> level 2
        cfg(1, 3, 0, "R2 cfg depth4");
        drv_glb = 0; drv_en = 1;
        idle("R6 enable");
        store("R3 first store");
        store("R8 level reached");
        store("R3 third store");
        store("R4 becomes full");
        store("R4 store while full lost");
        step(1, 1, 0, 0, 16'h0, "R4 store dropped read taken");
        step(1, 1, 0, 0, 16'h0, "R3 store and read same cycle");
        wstat(16'h0004, "R5 clear irq keep lost");
        wstat(16'h000C, "R5 write ones no effect");
        wstat(16'h0008, "R5 clear lost");
        store("R3 refill to full");
        step(1, 0, 1, 1, 16'h0000, "R5 set wins over clear");
        for (int i = 0; i < 6; i++) read("R3 drain and read empty");
        cfg(4, 0, 1, "R7 cfg ignored outside glb");
        for (int i = 0; i < 6; i++) store("R7 depth still 4");
        drv_en = 0;
        idle("R6 disabled");
        store("R6 store while disabled");
        drv_en = 1;
        idle("R6 reenabled");
        drv_glb = 1;
        idle("R7 glb clears");
        cfg(4, 7, 1, "R7 cfg depth32 every");
        drv_glb = 0;
        store("R9 every store irq");
        wstat(16'h0000, "R5 clear both");
        store("R9 irq again");
        for (int i = 0; i < 31; i++) store("R2 fill 32");
        store("R4 lost at 32");
        step(1, 1, 0, 0, 16'h0, "R4 wrap read at 32");
        drv_glb = 1;
        cfg(2, 1, 0, "R2 cfg depth8 level2");
        drv_glb = 0;
        store("R8 depth8 one");
        step(1, 1, 0, 0, 16'h0, "R8 store with read no irq");
        store("R8 depth8 reaches 2");
        drv_glb = 1;
        cfg(5, 0, 0, "R2 cfg invalid depth");
        drv_glb = 0;
        store("R2 invalid depth ignores store");
        idle("R2 stays empty");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule